// File: doc/BRIEF.md
# BCD Real-Time Clock Register File

This block keeps the time of day and the calendar for a battery-backed clock. It holds seven packed-BCD registers: seconds, minutes, hours, day of week, date, month and year. A once-per-second strobe advances them, with every carry rippling from seconds up to the year. Software reads and writes the registers one byte at a time over a small register port.

A stop flag lives in the top bit of the seconds register. While the flag is set the clock holds its time, and clearing it resumes from the held value. Each write is masked to its field and checked against that field's legal range. A write that fails the check is dropped with no trace, except for the stop flag and the century flag, which are stored on every write to their register.

A parameter names the calendar year that register value 0 stands for (for example 1900 or 1968). The leap-year rule follows from that base year.

Top module: `rtc_regfile`

## Requirements
- R1: After a synchronous active-low reset the registers read seconds 0x00, minutes 0x00, hours 0x00, day 0x01, date 0x01, month 0x01, year 0x00, with the stop and century flags clear.
- R2: The registers sit at offsets 1 (seconds), 2 (minutes), 3 (hours), 4 (day of week and century), 5 (date), 6 (month) and 7 (year). Every other offset reads 0x00, and writes to it change nothing.
- R3: Every write to offset 1 stores bit 7 as the stop flag. Bits 6:0 are taken as BCD seconds and accepted only for 00 to 59. A read returns the stop flag in bit 7 and the BCD seconds in bits 6:0.
- R4: Minutes writes use bits 6:0 and are accepted for 00 to 59. Hours writes use bits 5:0 and are accepted for 00 to 23. The unused read bits are 0.
- R5: Every write to offset 4 stores bit 6 as the century flag. Bits 2:0 are the day of week and are accepted for 1 to 7. A read returns the century flag in bit 6 and the day in bits 2:0.
- R6: Date writes use bits 5:0 and are accepted for 01 to 31. Month writes use bits 4:0 and are accepted for 01 to 12. Year writes use the full byte and are accepted for 00 to 99.
- R7: A write is rejected when either nibble of its masked field holds a digit above 9.
- R8: Each tick with the stop flag clear adds one second. Seconds wrap from 59 to 0 into minutes, minutes from 59 to 0 into hours, and hours from 23 to 0 into the day. Day of week wraps from 7 to 1, and the year wraps from 99 to 0 after December.
- R9: A day carry whose date is at or above the month length sets the date to 1 and advances the month. February has 29 days when (YEAR_BASE + year) is divisible by 4 and 28 days otherwise. April, June, September and November have 30 days, and the other months have 31.
- R10: While the stop flag is set, ticks change nothing. After the flag is cleared, counting resumes from the held time.
- R11: When an accepted write and a tick fall in the same cycle, the written field takes the written value. The other fields advance from their values before that cycle. The stop flag as it stood before that cycle decides whether the tick counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_1hz | input | 1 | One-cycle strobe, once per second |
| reg_addr | input | ADDR_W | Register offset for read and write |
| wr_en | input | 1 | Write strobe for the addressed register |
| wr_data | input | 8 | Byte to write |
| rd_data | output | 8 | Combinational read of the addressed register |

## Verification
The two functions that can land in the same cycle are the tick advance and a register write. The case that matters is a write that arrives while a carry ripples through several fields. The bench sets the clock to 59:59 and then raises the tick together with a write to each register in turn, including writes that set or clear the stop flag. Every register is then compared against a model: the written field holds the written value, and every other field shows the advance computed from the time before that cycle.

// File: rtl/rtc_pkg.sv
// Shared types, register offsets and BCD helpers for the clock register file.
// Assumes packed BCD with two digits per byte.
package rtc_pkg;

    localparam int OFS_SEC  = 1;
    localparam int OFS_MIN  = 2;
    localparam int OFS_HR   = 3;
    localparam int OFS_DOW  = 4;
    localparam int OFS_DATE = 5;
    localparam int OFS_MON  = 6;
    localparam int OFS_YR   = 7;

    // Time state held in binary.
    typedef struct packed {
        logic       stop;
        logic       cent;
        logic [5:0] sec;
        logic [5:0] min;
        logic [4:0] hr;
        logic [2:0] dow;
        logic [4:0] date;
        logic [3:0] mon;
        logic [6:0] yr;
    } rtc_time_t;

    // Per-field load requests with the binary values to load.
    typedef struct packed {
        logic      ld_stop;
        logic      ld_cent;
        logic      ld_sec;
        logic      ld_min;
        logic      ld_hr;
        logic      ld_dow;
        logic      ld_date;
        logic      ld_mon;
        logic      ld_yr;
        rtc_time_t val;
    } rtc_load_t;

    function automatic logic digits_ok(input logic [7:0] b);
        return (b[3:0] <= 4'd9) && (b[7:4] <= 4'd9);
    endfunction

    function automatic logic [6:0] bcd_to_bin(input logic [7:0] b);
        return 7'(7'(b[7:4]) * 7'd10 + 7'(b[3:0]));
    endfunction

    function automatic logic [7:0] bin_to_bcd(input logic [6:0] v);
        return {4'(v / 7'd10), 4'(v % 7'd10)};
    endfunction

    function automatic logic [4:0] month_len(input logic [3:0] m, input logic leap);
        case (m)
            4'd2:                     return leap ? 5'd29 : 5'd28;
            4'd4, 4'd6, 4'd9, 4'd11:  return 5'd30;
            default:                  return 5'd31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_wr_decode.sv
// Write decoder: masks the written byte per field, range-checks it and raises a
// load request for each accepted field. Stop and century flags load on every
// write to their register. Assumes one write per cycle.
module rtc_wr_decode
    import rtc_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    output rtc_load_t         ld
);

    logic [7:0] f_sec, f_hr, f_mon;
    logic [6:0] sec_b, hr_b, date_b, mon_b, yr_b;
    logic       ok_sec, ok_hr, ok_dow, ok_date, ok_mon, ok_yr;
    logic       hit_sec, hit_min, hit_hr, hit_dow, hit_date, hit_mon, hit_yr;

    // Field masking and conversion to binary.
    always_comb begin
        f_sec  = {1'b0, wr_data[6:0]};
        f_hr   = {2'b0, wr_data[5:0]};
        f_mon  = {3'b0, wr_data[4:0]};
        sec_b  = bcd_to_bin(f_sec);
        hr_b   = bcd_to_bin(f_hr);
        date_b = bcd_to_bin(f_hr);
        mon_b  = bcd_to_bin(f_mon);
        yr_b   = bcd_to_bin(wr_data);
    end

    // Range and digit checks per field (minutes share the seconds field shape).
    always_comb begin
        ok_sec  = digits_ok(f_sec) && (sec_b <= 7'd59);
        ok_hr   = digits_ok(f_hr) && (hr_b <= 7'd23);
        ok_dow  = (wr_data[2:0] != 3'd0);
        ok_date = digits_ok(f_hr) && (date_b >= 7'd1) && (date_b <= 7'd31);
        ok_mon  = digits_ok(f_mon) && (mon_b >= 7'd1) && (mon_b <= 7'd12);
        ok_yr   = digits_ok(wr_data);
    end

    // Offset decode.
    always_comb begin
        hit_sec  = wr_en && (wr_addr == ADDR_W'(OFS_SEC));
        hit_min  = wr_en && (wr_addr == ADDR_W'(OFS_MIN));
        hit_hr   = wr_en && (wr_addr == ADDR_W'(OFS_HR));
        hit_dow  = wr_en && (wr_addr == ADDR_W'(OFS_DOW));
        hit_date = wr_en && (wr_addr == ADDR_W'(OFS_DATE));
        hit_mon  = wr_en && (wr_addr == ADDR_W'(OFS_MON));
        hit_yr   = wr_en && (wr_addr == ADDR_W'(OFS_YR));
    end

    // Assemble the load request.
    always_comb begin
        ld          = '0;
        ld.val.stop = wr_data[7];
        ld.val.cent = wr_data[6];
        ld.val.sec  = 6'(sec_b);
        ld.val.min  = 6'(sec_b);
        ld.val.hr   = 5'(hr_b);
        ld.val.dow  = wr_data[2:0];
        ld.val.date = 5'(date_b);
        ld.val.mon  = 4'(mon_b);
        ld.val.yr   = yr_b;
        ld.ld_stop  = hit_sec;
        ld.ld_sec   = hit_sec && ok_sec;
        ld.ld_min   = hit_min && ok_sec;
        ld.ld_hr    = hit_hr && ok_hr;
        ld.ld_cent  = hit_dow;
        ld.ld_dow   = hit_dow && ok_dow;
        ld.ld_date  = hit_date && ok_date;
        ld.ld_mon   = hit_mon && ok_mon;
        ld.ld_yr    = hit_yr && ok_yr;
    end

endmodule

// File: rtl/rtc_time_core.sv
// Time core: holds the binary time state and advances it on each tick unless
// stopped, carrying up to the year. A load request overrides the advanced value
// of its own field only. Assumes tick_1hz is a one-cycle strobe.
module rtc_time_core
    import rtc_pkg::*;
#(
    parameter int YEAR_BASE = 1900
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick_1hz,
    input  rtc_load_t ld,
    output rtc_time_t cur
);

    localparam logic [1:0] LEAP_PH = 2'(YEAR_BASE % 4);

    rtc_time_t  adv, nxt;
    logic       run, c_min, c_hr, c_day, c_mon, c_yr, leap, any_ld;
    logic [4:0] mlen;

    // Carry chain from the current state.
    always_comb begin
        leap  = (2'(cur.yr[1:0] + LEAP_PH) == 2'b00);
        mlen  = month_len(cur.mon, leap);
        run   = tick_1hz && !cur.stop;
        c_min = run && (cur.sec == 6'd59);
        c_hr  = c_min && (cur.min == 6'd59);
        c_day = c_hr && (cur.hr == 5'd23);
        c_mon = c_day && (cur.date >= mlen);
        c_yr  = c_mon && (cur.mon == 4'd12);
    end

    // Advanced state for this tick.
    always_comb begin
        adv = cur;
        if (run)   adv.sec = (cur.sec == 6'd59) ? 6'd0 : cur.sec + 6'd1;
        if (c_min) adv.min = (cur.min == 6'd59) ? 6'd0 : cur.min + 6'd1;
        if (c_hr)  adv.hr  = (cur.hr == 5'd23) ? 5'd0 : cur.hr + 5'd1;
        if (c_day) begin
            adv.dow  = (cur.dow == 3'd7) ? 3'd1 : cur.dow + 3'd1;
            adv.date = c_mon ? 5'd1 : cur.date + 5'd1;
        end
        if (c_mon) adv.mon = (cur.mon == 4'd12) ? 4'd1 : cur.mon + 4'd1;
        if (c_yr)  adv.yr  = (cur.yr == 7'd99) ? 7'd0 : cur.yr + 7'd1;
    end

    // Per-field choice between written value and advanced value.
    always_comb begin
        nxt.stop = ld.ld_stop ? ld.val.stop : adv.stop;
        nxt.cent = ld.ld_cent ? ld.val.cent : adv.cent;
        nxt.sec  = ld.ld_sec  ? ld.val.sec  : adv.sec;
        nxt.min  = ld.ld_min  ? ld.val.min  : adv.min;
        nxt.hr   = ld.ld_hr   ? ld.val.hr   : adv.hr;
        nxt.dow  = ld.ld_dow  ? ld.val.dow  : adv.dow;
        nxt.date = ld.ld_date ? ld.val.date : adv.date;
        nxt.mon  = ld.ld_mon  ? ld.val.mon  : adv.mon;
        nxt.yr   = ld.ld_yr   ? ld.val.yr   : adv.yr;
        any_ld   = ld.ld_stop | ld.ld_cent | ld.ld_sec | ld.ld_min | ld.ld_hr |
                   ld.ld_dow | ld.ld_date | ld.ld_mon | ld.ld_yr;
    end

    // State register with reset to 00:00:00, day 1, 01/01/00.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur      <= '0;
            cur.dow  <= 3'd1;
            cur.date <= 5'd1;
            cur.mon  <= 4'd1;
        end else begin
            cur <= nxt;
        end
    end

    // R10
    frozen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur.stop && !any_ld) |=> $stable(cur));

    // R8
    sec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_1hz && !cur.stop && !ld.ld_sec && cur.sec != 6'd59)
        |=> (cur.sec == $past(cur.sec) + 6'd1));

    // R9
    date_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |-> (cur.date != 5'd0 && cur.mon != 4'd0 && cur.mon <= 4'd12));

    // R11
    load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld.ld_min |=> (cur.min == $past(ld.val.min)));

endmodule

// File: rtl/rtc_rd_mux.sv
// Read mux: turns the binary state of the addressed register into BCD with the
// stored flags in place. Offsets outside the map read zero. Purely combinational.
module rtc_rd_mux
    import rtc_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic [ADDR_W-1:0] rd_addr,
    input  rtc_time_t         cur,
    output logic [7:0]        rd_byte
);

    logic [7:0] sec_bcd;

    // Select and encode the addressed field.
    always_comb begin
        sec_bcd = bin_to_bcd(7'(cur.sec));
        case (rd_addr)
            ADDR_W'(OFS_SEC):  rd_byte = {cur.stop, sec_bcd[6:0]};
            ADDR_W'(OFS_MIN):  rd_byte = bin_to_bcd(7'(cur.min));
            ADDR_W'(OFS_HR):   rd_byte = bin_to_bcd(7'(cur.hr));
            ADDR_W'(OFS_DOW):  rd_byte = {1'b0, cur.cent, 3'b0, cur.dow};
            ADDR_W'(OFS_DATE): rd_byte = bin_to_bcd(7'(cur.date));
            ADDR_W'(OFS_MON):  rd_byte = bin_to_bcd(7'(cur.mon));
            ADDR_W'(OFS_YR):   rd_byte = bin_to_bcd(cur.yr);
            default:           rd_byte = 8'h00;
        endcase
    end

endmodule

// File: rtl/rtc_regfile.sv
// BCD real-time clock register file: a byte-wide register port over a ticking
// time core. Assumes one access per cycle and a one-cycle tick_1hz strobe.
module rtc_regfile
    import rtc_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int YEAR_BASE = 1900
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_1hz,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              wr_en,
    input  logic [7:0]        wr_data,
    output logic [7:0]        rd_data
);

    rtc_load_t ld;
    rtc_time_t cur_time;

    rtc_wr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .wr_en   (wr_en),
        .wr_addr (reg_addr),
        .wr_data (wr_data),
        .ld      (ld)
    );

    rtc_time_core #(.YEAR_BASE(YEAR_BASE)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_1hz (tick_1hz),
        .ld       (ld),
        .cur      (cur_time)
    );

    rtc_rd_mux #(.ADDR_W(ADDR_W)) u_rd (
        .rd_addr (reg_addr),
        .cur     (cur_time),
        .rd_byte (rd_data)
    );

    // R3
    stop_view_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == ADDR_W'(OFS_SEC)) |-> (rd_data[7] == cur_time.stop));

    // R6
    month_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_addr == ADDR_W'(OFS_MON) && wr_data[4:0] == 5'd0 && !tick_1hz)
        |=> $stable(cur_time.mon));

    // R2
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == '0 || reg_addr > ADDR_W'(OFS_YR)) |-> (rd_data == 8'h00));

endmodule

// File: tb/tb_rtc_regfile.sv
`timescale 1ns/100ps
module tb_rtc_regfile;

    typedef struct {
        int sec; int min; int hr; int dow; int date; int mon; int yr; int stop; int cent;
    } tm_t;

    localparam int BASE_A = 1900;
    localparam int BASE_B = 1970;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_1hz = 1'b0;
    logic [3:0] reg_addr = 4'd0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'd0;
    logic [7:0] rd_data, rd_data_b;

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;
    tm_t mdl[2];

    always #2.5 clk = ~clk;

    rtc_regfile #(.ADDR_W(4), .YEAR_BASE(BASE_A)) dut (
        .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .reg_addr(reg_addr),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data));

    rtc_regfile #(.ADDR_W(4), .YEAR_BASE(BASE_B)) dut_b (
        .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .reg_addr(reg_addr),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data_b));

    function automatic int i2b(int i);
        return ((i / 10) << 4) | (i % 10);
    endfunction

    function automatic int b2i(int b);
        return ((b >> 4) & 15) * 10 + (b & 15);
    endfunction

    function automatic bit nib_ok(int b);
        return ((b & 15) <= 9) && (((b >> 4) & 15) <= 9);
    endfunction

    function automatic int mlen(int m, int y, int base);
        if (m == 2) return (((base + y) % 4) == 0) ? 29 : 28;
        if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
        return 31;
    endfunction

    function automatic tm_t reset_tm();
        tm_t t;
        t.sec = 0; t.min = 0; t.hr = 0; t.dow = 1; t.date = 1; t.mon = 1;
        t.yr = 0; t.stop = 0; t.cent = 0;
        return t;
    endfunction

    // One second of advance, per R8 and R9.
    function automatic tm_t adv(tm_t t, int base);
        int len;
        if (t.stop != 0) return t;
        len = mlen(t.mon, t.yr, base);
        t.sec++;
        if (t.sec == 60) begin
            t.sec = 0; t.min++;
            if (t.min == 60) begin
                t.min = 0; t.hr++;
                if (t.hr == 24) begin
                    t.hr = 0;
                    t.dow = (t.dow == 7) ? 1 : t.dow + 1;
                    if (t.date >= len) begin
                        t.date = 1; t.mon++;
                        if (t.mon == 13) begin
                            t.mon = 1;
                            t.yr = (t.yr == 99) ? 0 : t.yr + 1;
                        end
                    end else t.date++;
                end
            end
        end
        return t;
    endfunction

    // Write acceptance, per R2 to R7.
    function automatic tm_t wmod(tm_t t, int a, int d);
        int f;
        case (a)
            1: begin
                t.stop = (d >> 7) & 1; f = d & 'h7F;
                if (nib_ok(f) && b2i(f) <= 59) t.sec = b2i(f);
            end
            2: begin f = d & 'h7F; if (nib_ok(f) && b2i(f) <= 59) t.min = b2i(f); end
            3: begin f = d & 'h3F; if (nib_ok(f) && b2i(f) <= 23) t.hr = b2i(f); end
            4: begin t.cent = (d >> 6) & 1; f = d & 7; if (f >= 1) t.dow = f; end
            5: begin f = d & 'h3F; if (nib_ok(f) && b2i(f) >= 1 && b2i(f) <= 31) t.date = b2i(f); end
            6: begin f = d & 'h1F; if (nib_ok(f) && b2i(f) >= 1 && b2i(f) <= 12) t.mon = b2i(f); end
            7: begin if (nib_ok(d)) t.yr = b2i(d); end
            default: ;
        endcase
        return t;
    endfunction

    function automatic int exp_rd(tm_t t, int a);
        case (a)
            1: return (t.stop << 7) | i2b(t.sec);
            2: return i2b(t.min);
            3: return i2b(t.hr);
            4: return (t.cent << 6) | t.dow;
            5: return i2b(t.date);
            6: return i2b(t.mon);
            7: return i2b(t.yr);
            default: return 0;
        endcase
    endfunction

    task automatic chk(string tag, string what, int act, int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s %s: actual=%02h expected=%02h", tag, what, act, expv);
        end
    endtask

    // One clock cycle with optional write and tick; model updated after the edge.
    task automatic cyc(bit we, int a, int d, bit tk);
        @(negedge clk);
        wr_en = we; reg_addr = 4'(a); wr_data = 8'(d); tick_1hz = tk;
        @(posedge clk);
        for (int i = 0; i < 2; i++) begin
            if (tk) mdl[i] = adv(mdl[i], (i == 0) ? BASE_A : BASE_B);
            if (we) mdl[i] = wmod(mdl[i], a, d);
        end
        #1;
        wr_en = 1'b0; tick_1hz = 1'b0;
    endtask

    task automatic rd(int a, output int v0, output int v1);
        reg_addr = 4'(a);
        #1;
        v0 = rd_data; v1 = rd_data_b;
    endtask

    task automatic check_all(string tag);
        int v0, v1;
        for (int a = 1; a <= 7; a++) begin
            rd(a, v0, v1);
            chk(tag, $sformatf("base%0d reg%0d", BASE_A, a), v0, exp_rd(mdl[0], a));
            chk(tag, $sformatf("base%0d reg%0d", BASE_B, a), v1, exp_rd(mdl[1], a));
        end
    endtask

    task automatic set_time(int s, int mi, int h, int dw, int dt, int mo, int y);
        cyc(1, 1, i2b(s), 0);
        cyc(1, 2, i2b(mi), 0);
        cyc(1, 3, i2b(h), 0);
        cyc(1, 4, dw, 0);
        cyc(1, 5, i2b(dt), 0);
        cyc(1, 6, i2b(mo), 0);
        cyc(1, 7, i2b(y), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int v0, v1;
        string tg;
        int coll [8];
        mdl[0] = reset_tm(); mdl[1] = reset_tm();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        check_all("R1");

        // R3 R4 R5 R6 R7: exhaustive write sweep of every register
        for (int a = 1; a <= 7; a++) begin
            tg = (a == 1) ? "R3" : (a <= 3) ? "R4" : (a == 4) ? "R5" : "R6";
            for (int v = 0; v < 256; v++) begin
                cyc(1, a, v, 0);
                rd(a, v0, v1);
                chk(tg, $sformatf("reg%0d after write %02h", a, v), v0, exp_rd(mdl[0], a));
                chk(tg, $sformatf("reg%0d after write %02h (b)", a, v), v1, exp_rd(mdl[1], a));
            end
        end

        // R7 digit above 9 in a field is rejected
        set_time(12, 34, 5, 3, 15, 6, 42);
        cyc(1, 2, 'h1A, 0);
        cyc(1, 7, 'hA1, 0);
        cyc(1, 5, 'h0F, 0);
        check_all("R7");

        // R2 unmapped offsets read zero and ignore writes
        for (int a = 0; a < 16; a++) begin
            if (a >= 1 && a <= 7) continue;
            cyc(1, a, 'h55, 0);
            rd(a, v0, v1);
            chk("R2", $sformatf("unmapped offset %0d", a), v0, 0);
        end
        check_all("R2");

        // R8 long run across day, month and year rollover
        set_time(0, 58, 23, 7, 31, 12, 99);
        for (int k = 0; k < 130; k++) begin
            cyc(0, 0, 0, 1);
            check_all("R8");
        end
        set_time(0, 0, 0, 1, 1, 1, 0);
        for (int k = 0; k < 3700; k++) begin
            cyc(0, 0, 0, 1);
            if (k % 4 == 0) check_all("R8");
        end

        // R9 month ends for four year phases and both base years
        for (int y = 0; y < 4; y++)
            for (int m = 1; m <= 12; m++)
                for (int d = 28; d <= 31; d++) begin
                    set_time(59, 59, 23, 3, d, m, y);
                    cyc(0, 0, 0, 1);
                    check_all("R9");
                end

        // R10 stop flag freezes and release resumes
        set_time(10, 0, 0, 1, 1, 1, 0);
        cyc(1, 1, 'h80 | i2b(20), 0);
        for (int k = 0; k < 5; k++) begin
            cyc(0, 0, 0, 1);
            check_all("R10");
        end
        cyc(1, 1, i2b(20), 0);
        cyc(0, 0, 0, 1);
        check_all("R10");
        // R3 rejected seconds value still stores the stop flag
        cyc(1, 1, 'hFA, 0);
        check_all("R3");

        // R11 write and tick in the same cycle while a carry ripples
        coll[1] = 'hB0; coll[2] = 'h15; coll[3] = 'h05; coll[4] = 'h43;
        coll[5] = 'h12; coll[6] = 'h06; coll[7] = 'h25;
        for (int a = 1; a <= 7; a++) begin
            set_time(59, 59, 23, 7, 30, 4, 3);
            cyc(1, a, coll[a], 1);
            check_all("R11");
        end
        // R11 stopped before the cycle: tick ignored even though the write clears stop
        cyc(1, 1, 'h80 | i2b(40), 0);
        cyc(1, 1, i2b(10), 1);
        check_all("R11");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule